// File: doc/BRIEF.md
# Speculative Task Store Buffer with Dependence Check

This block sits between a ring of processing units that run speculative tasks and a data cache. Each task is named by its slot in a ring of task slots. A head pointer marks the oldest task, which is not speculative. Loads and stores from the other tasks are recorded in a small fully associative buffer. Speculative stores never reach the cache. A load from a speculative task takes its value from the nearest older buffered store to the same address, and from the cache if there is none.

Every entry keeps one load bit and one store bit per task slot. When a store from a task meets an address that a younger task has already loaded, that younger task read a stale value. The block reports a violation that names the oldest such younger task. In the same clock edge it discards everything recorded for that task and for all tasks behind it.

On commit, the head task's buffered stores drain to the cache at one per cycle, and then the head pointer moves on. When a speculative access needs a new entry and none is free, `full_o` tells the controller to stall or squash.

Top module: `sab_spec_buffer`

## Requirements
- R1: While reset is held and on the first cycle after it, `head_o` is 0, and `drain_o`, `viol_o`, `rsp_valid_o`, `full_o` and `cache_wr_en_o` are all low, provided the inputs are idle.
- R2: A store from the head task is written to the cache in the same cycle (`cache_wr_en_o`, address, data). If the address hits an entry, the head task's own buffered store there is dropped. A load from the head task returns, one cycle later, the head's own buffered store if one exists, or otherwise the cache data.
- R3: A store from a non-head task never drives `cache_wr_en_o`. Outside a drain, the cache is written only by head-task stores.
- R4: A load from a non-head task is answered one cycle later with `rsp_valid_o` high. `rsp_data_o` is the value of the youngest buffered store to that address whose task is not younger than the loading task. If there is no such store, it is the cache data.
- R5: A store from task T to an address that some task younger than T has loaded raises `viol_o` one cycle later. `viol_task_o` names the oldest such younger task. At that edge, all load and store bits of that task and every younger task are cleared.
- R6: A non-head request whose address misses every occupied entry, while all 8 entries are occupied, raises `full_o` combinationally in the same cycle. The request is dropped: no response and no state change.
- R7: After `commit_i`, `drain_o` is high from the next cycle. Each draining cycle writes one of the head task's buffered stores to the cache, lowest entry index first. One further cycle follows with no write. Then `drain_o` falls and `head_o` increments modulo 4, so a commit with S buffered stores keeps `drain_o` high for S+1 cycles.
- R8: `squash_i` with `squash_task_i` clears, in one cycle, every load and store bit of that task and of all younger tasks. Later loads no longer see the squashed stores.
- R9: Age is taken as (task − head) modulo 4. With the head at slot 3, slot 0 is younger than slot 3 for both forwarding and violation checks.
- R10: An entry whose bits are all cleared by a drain or a squash is free again, so a request that was refused as full is accepted once space is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Memory request present |
| req_task_i | input | 2 | Ring slot of the requesting task |
| req_store_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | 16 | Word address |
| req_wdata_i | input | 32 | Store data |
| rsp_valid_o | output | 1 | Load data valid (one cycle after the load) |
| rsp_data_o | output | 32 | Load data |
| viol_o | output | 1 | Dependence violation detected on the previous cycle |
| viol_task_o | output | 2 | Task that was squashed because of the violation |
| squash_i | input | 1 | Controller squash request |
| squash_task_i | input | 2 | Oldest task to squash |
| commit_i | input | 1 | Commit the head task |
| drain_o | output | 1 | Head task's stores are draining |
| head_o | output | 2 | Current head slot |
| full_o | output | 1 | Request needs an entry and none is free |
| cache_rd_addr_o | output | 16 | Cache read address (same-cycle read) |
| cache_rd_data_i | input | 32 | Cache read data |
| cache_wr_en_o | output | 1 | Cache write strobe |
| cache_wr_addr_o | output | 16 | Cache write address |
| cache_wr_data_o | output | 32 | Cache write data |

## Verification
The assertions assume the controller keeps requests, commits and squashes quiet while `drain_o` is high. They also assume it never raises `squash_i` in the same cycle as a request or a commit, and that the cache answers reads in the same cycle. The stimulus generator follows the same rules: it issues only idle cycles while its model shows a drain in progress, and it picks exactly one action per cycle. Addresses come from a 16-word range so that hits, full conditions and cross-task conflicts all occur often.

// File: rtl/sab_pkg.sv
// Shared types for the speculative store buffer.
// Assumes nothing beyond IEEE 1800-2017 enums.
package sab_pkg;
    // Operating mode of the buffer: normal accesses or draining the head task
    typedef enum logic {
        SAB_RUN   = 1'b0,
        SAB_DRAIN = 1'b1
    } sab_mode_e;
endpackage

// File: rtl/sab_lookup.sv
// Associative lookup over the buffer entries.
// Returns the lowest matching occupied entry and the lowest free entry.
// Assumes at most one occupied entry holds any given address.
module sab_lookup #(
    parameter int N_ENTRY = 8,
    parameter int AW      = 16,
    localparam int IDX_W  = $clog2(N_ENTRY)
) (
    input  logic [AW-1:0]      tag_i [N_ENTRY],
    input  logic [N_ENTRY-1:0] used_i,
    input  logic [AW-1:0]      addr_i,
    output logic               hit_o,
    output logic [IDX_W-1:0]   hit_idx_o,
    output logic               free_any_o,
    output logic [IDX_W-1:0]   free_idx_o
);
    logic [N_ENTRY-1:0] match;

    for (genvar g = 0; g < N_ENTRY; g++) begin : g_cmp
        assign match[g] = used_i[g] && (tag_i[g] == addr_i);
    end

    // Priority-encode the match and free vectors, lowest index wins
    always_comb begin
        hit_idx_o  = '0;
        free_idx_o = '0;
        for (int i = N_ENTRY - 1; i >= 0; i--) begin
            if (match[i])   hit_idx_o  = IDX_W'(i);
            if (!used_i[i]) free_idx_o = IDX_W'(i);
        end
    end

    assign hit_o      = |match;
    assign free_any_o = ~&used_i;
endmodule

// File: rtl/sab_ring_pick.sv
// Picks one task slot from a per-slot bit vector by age on the ring.
// Age of slot s is (s - head) modulo N_TASK; N_TASK must be a power of two.
// PICK_YOUNGER = 0: youngest set slot whose age is <= the reference age (forwarding).
// PICK_YOUNGER = 1: oldest set slot whose age is > the reference age (violation).
module sab_ring_pick #(
    parameter int N_TASK       = 4,
    parameter bit PICK_YOUNGER = 1'b0,
    localparam int TID_W       = $clog2(N_TASK)
) (
    input  logic [N_TASK-1:0] bits_i,
    input  logic [TID_W-1:0]  head_i,
    input  logic [TID_W-1:0]  ref_i,
    output logic              found_o,
    output logic [TID_W-1:0]  slot_o
);
    logic [TID_W-1:0] ref_age;
    assign ref_age = ref_i - head_i;

    if (PICK_YOUNGER) begin : g_younger
        // Walk ages upward from just past the reference, first set slot wins
        always_comb begin
            found_o = 1'b0;
            slot_o  = '0;
            for (int k = 0; k < N_TASK; k++) begin
                if (!found_o && (TID_W'(k) > ref_age) && bits_i[head_i + TID_W'(k)]) begin
                    found_o = 1'b1;
                    slot_o  = head_i + TID_W'(k);
                end
            end
        end
    end else begin : g_older
        // Walk ages downward from the reference, first set slot wins
        always_comb begin
            found_o = 1'b0;
            slot_o  = '0;
            for (int k = N_TASK - 1; k >= 0; k--) begin
                if (!found_o && (TID_W'(k) <= ref_age) && bits_i[head_i + TID_W'(k)]) begin
                    found_o = 1'b1;
                    slot_o  = head_i + TID_W'(k);
                end
            end
        end
    end
endmodule

// File: rtl/sab_spec_buffer.sv
// Speculative store buffer with memory dependence checking across ring tasks.
// Holds stores of speculative tasks until commit, forwards them to younger
// loads, and flags a younger task whose load was overtaken by an older store.
// Assumes: no request, commit or squash while drain_o is high; squash_i is
// never raised together with a request or commit; the cache read is combinational.
module sab_spec_buffer #(
    parameter int N_ENTRY = 8,
    parameter int N_TASK  = 4,
    parameter int AW      = 16,
    parameter int DW      = 32,
    localparam int IDX_W  = $clog2(N_ENTRY),
    localparam int TID_W  = $clog2(N_TASK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    input  logic [TID_W-1:0] req_task_i,
    input  logic             req_store_i,
    input  logic [AW-1:0]    req_addr_i,
    input  logic [DW-1:0]    req_wdata_i,
    output logic             rsp_valid_o,
    output logic [DW-1:0]    rsp_data_o,
    output logic             viol_o,
    output logic [TID_W-1:0] viol_task_o,
    input  logic             squash_i,
    input  logic [TID_W-1:0] squash_task_i,
    input  logic             commit_i,
    output logic             drain_o,
    output logic [TID_W-1:0] head_o,
    output logic             full_o,
    output logic [AW-1:0]    cache_rd_addr_o,
    input  logic [DW-1:0]    cache_rd_data_i,
    output logic             cache_wr_en_o,
    output logic [AW-1:0]    cache_wr_addr_o,
    output logic [DW-1:0]    cache_wr_data_o
);
    import sab_pkg::*;

    logic [AW-1:0]     tag_q [N_ENTRY];
    logic [DW-1:0]     val_q [N_ENTRY][N_TASK];
    logic [N_TASK-1:0] ld_q  [N_ENTRY];
    logic [N_TASK-1:0] st_q  [N_ENTRY];
    logic [N_TASK-1:0] ld_d  [N_ENTRY];
    logic [N_TASK-1:0] st_d  [N_ENTRY];
    logic [TID_W-1:0]  head_q;
    sab_mode_e         mode_q;
    logic              rsp_valid_q, viol_q;
    logic [DW-1:0]     rsp_data_q;
    logic [TID_W-1:0]  viol_task_q;

    logic [N_ENTRY-1:0] used;
    logic               hit, free_any;
    logic [IDX_W-1:0]   hit_idx, free_idx, wr_idx, drn_idx;
    logic [N_TASK-1:0]  hit_ld, hit_st, kill;
    logic               acc, is_head, take, ld_accept, viol_hit, drn_found;
    logic               fwd_found, vic_found;
    logic [TID_W-1:0]   fwd_slot, vic_slot;
    logic [DW-1:0]      ld_data;

    // Mask of the given task and every task younger than it
    function automatic logic [N_TASK-1:0] younger_mask(input logic [TID_W-1:0] from,
                                                       input logic [TID_W-1:0] hd);
        logic [TID_W-1:0] a_from, a_s;
        younger_mask = '0;
        a_from = from - hd;
        for (int s = 0; s < N_TASK; s++) begin
            a_s = TID_W'(s) - hd;
            younger_mask[s] = (a_s >= a_from);
        end
    endfunction

    for (genvar g = 0; g < N_ENTRY; g++) begin : g_used
        assign used[g] = (|ld_q[g]) || (|st_q[g]);
    end

    sab_lookup #(.N_ENTRY(N_ENTRY), .AW(AW)) lookup_i (
        .tag_i(tag_q), .used_i(used), .addr_i(req_addr_i),
        .hit_o(hit), .hit_idx_o(hit_idx), .free_any_o(free_any), .free_idx_o(free_idx)
    );

    assign hit_ld = hit ? ld_q[hit_idx] : '0;
    assign hit_st = hit ? st_q[hit_idx] : '0;

    sab_ring_pick #(.N_TASK(N_TASK), .PICK_YOUNGER(1'b0)) fwd_pick_i (
        .bits_i(hit_st), .head_i(head_q), .ref_i(req_task_i),
        .found_o(fwd_found), .slot_o(fwd_slot)
    );

    sab_ring_pick #(.N_TASK(N_TASK), .PICK_YOUNGER(1'b1)) vic_pick_i (
        .bits_i(hit_ld), .head_i(head_q), .ref_i(req_task_i),
        .found_o(vic_found), .slot_o(vic_slot)
    );

    // Request qualification and entry selection
    assign acc       = req_valid_i && (mode_q == SAB_RUN) && !squash_i;
    assign is_head   = (req_task_i == head_q);
    assign full_o    = acc && !is_head && !hit && !free_any;
    assign take      = acc && !is_head && !full_o;
    assign wr_idx    = hit ? hit_idx : free_idx;
    assign viol_hit  = acc && req_store_i && vic_found;
    assign ld_accept = acc && !req_store_i && !full_o;
    assign ld_data   = fwd_found ? val_q[hit_idx][fwd_slot] : cache_rd_data_i;

    // Lowest entry still holding a store of the head task
    always_comb begin
        drn_found = 1'b0;
        drn_idx   = '0;
        for (int i = N_ENTRY - 1; i >= 0; i--) begin
            if (st_q[i][head_q]) begin
                drn_found = 1'b1;
                drn_idx   = IDX_W'(i);
            end
        end
    end

    // Next value of the per-task load and store bits
    always_comb begin
        ld_d = ld_q;
        st_d = st_q;
        kill = '0;
        if (mode_q == SAB_DRAIN) begin
            if (drn_found) begin
                st_d[drn_idx][head_q] = 1'b0;
            end else begin
                for (int i = 0; i < N_ENTRY; i++) ld_d[i][head_q] = 1'b0;
            end
        end else if (squash_i) begin
            kill = younger_mask(squash_task_i, head_q);
        end else begin
            if (take && req_store_i)  st_d[wr_idx][req_task_i] = 1'b1;
            if (take && !req_store_i) ld_d[wr_idx][req_task_i] = 1'b1;
            if (acc && is_head && req_store_i && hit) st_d[hit_idx][head_q] = 1'b0;
            if (viol_hit) kill = younger_mask(vic_slot, head_q);
        end
        for (int i = 0; i < N_ENTRY; i++) begin
            ld_d[i] = ld_d[i] & ~kill;
            st_d[i] = st_d[i] & ~kill;
        end
    end

    // Control state, bit arrays and registered responses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENTRY; i++) begin
                ld_q[i] <= '0;
                st_q[i] <= '0;
            end
            head_q      <= '0;
            mode_q      <= SAB_RUN;
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
            viol_q      <= 1'b0;
            viol_task_q <= '0;
        end else begin
            ld_q        <= ld_d;
            st_q        <= st_d;
            rsp_valid_q <= ld_accept;
            viol_q      <= viol_hit;
            if (ld_accept) rsp_data_q  <= ld_data;
            if (viol_hit)  viol_task_q <= vic_slot;
            if (mode_q == SAB_DRAIN) begin
                if (!drn_found) begin
                    mode_q <= SAB_RUN;
                    head_q <= head_q + TID_W'(1);
                end
            end else if (!squash_i && commit_i) begin
                mode_q <= SAB_DRAIN;
            end
        end
    end

    // Entry address tags and store values (no reset needed, guarded by bits)
    always_ff @(posedge clk) begin
        if (take && !hit)        tag_q[wr_idx]             <= req_addr_i;
        if (take && req_store_i) val_q[wr_idx][req_task_i] <= req_wdata_i;
    end

    // Cache port: drain writes take the port, otherwise head stores bypass
    always_comb begin
        if (mode_q == SAB_DRAIN) begin
            cache_wr_en_o   = drn_found;
            cache_wr_addr_o = tag_q[drn_idx];
            cache_wr_data_o = val_q[drn_idx][head_q];
        end else begin
            cache_wr_en_o   = acc && is_head && req_store_i;
            cache_wr_addr_o = req_addr_i;
            cache_wr_data_o = req_wdata_i;
        end
    end

    assign cache_rd_addr_o = req_addr_i;
    assign rsp_valid_o     = rsp_valid_q;
    assign rsp_data_o      = rsp_data_q;
    assign viol_o          = viol_q;
    assign viol_task_o     = viol_task_q;
    assign drain_o         = (mode_q == SAB_DRAIN);
    assign head_o          = head_q;
endmodule

// File: rtl/sab_spec_buffer_chk.sv
// Port-level property checker for sab_spec_buffer, bound to every instance.
// Assumes the controller rules listed in the top module header.
module sab_spec_buffer_chk #(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int TID_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid_i,
    input logic [TID_W-1:0] req_task_i,
    input logic             req_store_i,
    input logic [AW-1:0]    req_addr_i,
    input logic [DW-1:0]    req_wdata_i,
    input logic             rsp_valid_o,
    input logic             viol_o,
    input logic [TID_W-1:0] viol_task_o,
    input logic             squash_i,
    input logic             commit_i,
    input logic             drain_o,
    input logic [TID_W-1:0] head_o,
    input logic             full_o,
    input logic             cache_wr_en_o,
    input logic [AW-1:0]    cache_wr_addr_o,
    input logic [DW-1:0]    cache_wr_data_o
);
    // R3
    wr_only_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cache_wr_en_o |-> (drain_o || (req_valid_i && req_store_i && req_task_i == head_o)));

    // R2
    head_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_store_i && req_task_i == head_o && !drain_o && !squash_i)
        |-> (cache_wr_en_o && cache_wr_addr_o == req_addr_i && cache_wr_data_o == req_wdata_i));

    // R4
    rsp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> $past(req_valid_i && !req_store_i && !full_o));

    // R5
    viol_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |-> ($past(req_valid_i && req_store_i) && viol_task_o != head_o));

    // R6
    full_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> (req_valid_i && req_task_i != head_o && !drain_o));

    // R7
    drain_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drain_o) |-> $past(commit_i));

    // R7
    drain_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drain_o) |-> (head_o == $past(head_o) + TID_W'(1)));

    // R7
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!drain_o && $past(!drain_o)) |-> (head_o == $past(head_o)));
endmodule

bind sab_spec_buffer sab_spec_buffer_chk #(.AW(AW), .DW(DW), .TID_W(TID_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_task_i(req_task_i),
    .req_store_i(req_store_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .rsp_valid_o(rsp_valid_o), .viol_o(viol_o), .viol_task_o(viol_task_o),
    .squash_i(squash_i), .commit_i(commit_i), .drain_o(drain_o), .head_o(head_o),
    .full_o(full_o), .cache_wr_en_o(cache_wr_en_o), .cache_wr_addr_o(cache_wr_addr_o),
    .cache_wr_data_o(cache_wr_data_o)
);

// File: tb/sab_spec_buffer_tb.sv
`timescale 1ns/1ps
// Self-checking bench: directed corners, then seeded random traffic,
// all compared cycle by cycle against a behavioural model of the requirements.
module sab_spec_buffer_tb_top;
    localparam int NE = 8, NT = 4, AW = 16, DW = 32, TW = 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n;
    logic          req_valid_i, req_store_i, squash_i, commit_i;
    logic [TW-1:0] req_task_i, squash_task_i;
    logic [AW-1:0] req_addr_i;
    logic [DW-1:0] req_wdata_i;
    logic          rsp_valid_o, viol_o, drain_o, full_o, cache_wr_en_o;
    logic [DW-1:0] rsp_data_o, cache_rd_data_i, cache_wr_data_o;
    logic [TW-1:0] viol_task_o, head_o;
    logic [AW-1:0] cache_rd_addr_o, cache_wr_addr_o;

    sab_spec_buffer dut_i (.*);

    // Cache model: same-cycle read, write at the clock edge
    logic [DW-1:0] mem [16];
    assign cache_rd_data_i = mem[cache_rd_addr_o[3:0]];
    always @(posedge clk) begin
        if (!rst_n) for (int i = 0; i < 16; i++) mem[i] <= 32'h1000 + i;
        else if (cache_wr_en_o) mem[cache_wr_addr_o[3:0]] <= cache_wr_data_o;
    end

    // Behavioural model state
    logic [AW-1:0] m_tag [NE];
    logic [NT-1:0] m_ld [NE], m_st [NE];
    logic [DW-1:0] m_val [NE][NT];
    logic [TW-1:0] m_head, e_vt;
    bit            m_drain, e_rv, e_v;
    logic [DW-1:0] e_rd;
    bit            s_full, s_wr;
    logic [AW-1:0] s_wra;
    logic [DW-1:0] s_wrd;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    task automatic chk(string r, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", r, got, exp);
        end
    endtask

    function automatic logic [TW-1:0] age(logic [TW-1:0] t);
        return t - m_head;
    endfunction

    function automatic void kill_from(logic [TW-1:0] f);
        for (int i = 0; i < NE; i++)
            for (int s = 0; s < NT; s++)
                if (age(TW'(s)) >= age(f)) begin
                    m_ld[i][s] = 1'b0;
                    m_st[i][s] = 1'b0;
                end
    endfunction

    // One clock cycle: drive, check combinational outputs, advance model, check registered outputs
    task automatic step(bit v, logic [TW-1:0] t, bit st, logic [AW-1:0] a, logic [DW-1:0] d,
                        bit cm, bit sq, logic [TW-1:0] sqt);
        bit hit = 0, fr = 0, df = 0, ew, ef, found;
        int hi = 0, fi = 0, di = 0, idx;
        logic [AW-1:0] ea;
        logic [DW-1:0] ed;
        @(negedge clk);
        req_valid_i = v; req_task_i = t; req_store_i = st; req_addr_i = a; req_wdata_i = d;
        commit_i = cm; squash_i = sq; squash_task_i = sqt;
        #1;
        for (int i = NE - 1; i >= 0; i--) begin
            if ((m_ld[i] | m_st[i]) != 0 && m_tag[i] == a) begin hit = 1; hi = i; end
            if ((m_ld[i] | m_st[i]) == 0) begin fr = 1; fi = i; end
            if (m_st[i][m_head]) begin df = 1; di = i; end
        end
        if (m_drain) begin ew = df; ea = m_tag[di]; ed = m_val[di][m_head]; end
        else begin ew = v && !sq && t == m_head && st; ea = a; ed = d; end
        ef = !m_drain && v && !sq && t != m_head && !hit && !fr;
        s_full = full_o; s_wr = cache_wr_en_o; s_wra = cache_wr_addr_o; s_wrd = cache_wr_data_o;
        chk("R6 full_o", full_o, ef);
        chk("R3 cache_wr_en_o", cache_wr_en_o, ew);
        if (ew) begin
            chk("R7 cache_wr_addr_o", cache_wr_addr_o, ea);
            chk("R7 cache_wr_data_o", cache_wr_data_o, ed);
        end
        e_rv = 0; e_v = 0;
        if (m_drain) begin
            if (df) m_st[di][m_head] = 1'b0;
            else begin
                for (int i = 0; i < NE; i++) m_ld[i][m_head] = 1'b0;
                m_head++; m_drain = 0;
            end
        end else if (sq) begin
            kill_from(sqt);
        end else begin
            if (cm) m_drain = 1;
            if (v && !ef) begin
                found = 0;
                if (st && hit)
                    for (int k = 1; k < NT; k++)
                        if (!found && k > age(t) && m_ld[hi][m_head + TW'(k)]) begin
                            found = 1; e_v = 1; e_vt = m_head + TW'(k);
                        end
                if (!st) begin
                    e_rv = 1; e_rd = mem[a[3:0]];
                    if (hit)
                        for (int k = NT - 1; k >= 0; k--)
                            if (!found && k <= age(t) && m_st[hi][m_head + TW'(k)]) begin
                                found = 1; e_rd = m_val[hi][m_head + TW'(k)];
                            end
                end
                if (t == m_head) begin
                    if (st && hit) m_st[hi][m_head] = 1'b0;
                end else begin
                    idx = hit ? hi : fi;
                    if (!hit) m_tag[idx] = a;
                    if (st) begin m_st[idx][t] = 1'b1; m_val[idx][t] = d; end
                    else m_ld[idx][t] = 1'b1;
                end
                if (e_v) kill_from(e_vt);
            end
        end
        @(posedge clk); #1;
        chk("R4 rsp_valid_o", rsp_valid_o, e_rv);
        if (e_rv) chk("R4 rsp_data_o", rsp_data_o, e_rd);
        chk("R5 viol_o", viol_o, e_v);
        if (e_v) chk("R5 viol_task_o", viol_task_o, e_vt);
        chk("R7 head_o", head_o, m_head);
        chk("R7 drain_o", drain_o, m_drain);
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic req(logic [TW-1:0] t, bit st, logic [AW-1:0] a, logic [DW-1:0] d);
        step(1, t, st, a, d, 0, 0, 0);
    endtask

    task automatic drain_all(output int n);
        n = 0;
        while (m_drain) begin idle(); n++; end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        #(10 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'd20240611));
        rst_n = 0; req_valid_i = 0; req_task_i = 0; req_store_i = 0; req_addr_i = 0;
        req_wdata_i = 0; commit_i = 0; squash_i = 0; squash_task_i = 0;
        for (int i = 0; i < NE; i++) begin m_ld[i] = 0; m_st[i] = 0; m_tag[i] = 0; end
        m_head = 0; m_drain = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 head_o", head_o, 0);
        chk("R1 drain_o", drain_o, 0);
        chk("R1 viol_o", viol_o, 0);
        chk("R1 rsp_valid_o", rsp_valid_o, 0);
        chk("R1 full_o", full_o, 0);
        chk("R1 cache_wr_en_o", cache_wr_en_o, 0);
        rst_n = 1;

        // R2 head store bypasses to cache, head load sees it
        req(0, 1, 3, 32'hAAAA0003);
        chk("R2 bypass wr", s_wr, 1);
        chk("R2 bypass data", s_wrd, 32'hAAAA0003);
        req(0, 0, 3, 0);
        chk("R2 head load", rsp_data_o, 32'hAAAA0003);

        // R3/R4 speculative stores and forwarding
        req(2, 1, 5, 32'h55);
        chk("R3 no spec write", s_wr, 0);
        req(1, 1, 5, 32'h51);
        req(3, 0, 5, 0);
        chk("R4 fwd from task2", rsp_data_o, 32'h55);
        req(1, 0, 5, 0);
        chk("R4 fwd own task", rsp_data_o, 32'h51);
        req(2, 0, 7, 0);
        chk("R4 miss to cache", rsp_data_o, 32'h1007);
        req(0, 0, 5, 0);
        chk("R3 cache untouched", rsp_data_o, 32'h1005);

        // R5 older store after younger load
        req(1, 1, 5, 32'h61);
        chk("R5 viol raised", viol_o, 1);
        chk("R5 victim", viol_task_o, 3);

        // R8 squash removes task2 store
        step(0, 0, 0, 0, 0, 0, 1, 2);
        req(3, 0, 5, 0);
        chk("R8 after squash", rsp_data_o, 32'h61);

        // R7 commits and drain
        step(0, 0, 0, 0, 0, 1, 0, 0);
        drain_all(n);
        chk("R7 empty drain len", n, 1);
        chk("R7 head after commit", head_o, 1);
        step(0, 0, 0, 0, 0, 1, 0, 0);
        drain_all(n);
        chk("R7 one store drain len", n, 2);
        req(2, 0, 5, 0);
        chk("R7 drained value", rsp_data_o, 32'h61);

        // R6 fill all entries, then overflow
        step(0, 0, 0, 0, 0, 0, 1, 3);
        for (int a = 8; a < 16; a++) req(3, 1, AW'(a), 32'h300 + a);
        req(0, 0, 0, 0);
        chk("R6 full seen", s_full, 1);
        chk("R6 dropped", rsp_valid_o, 0);

        // R9 wrap-around ordering with head at slot 3
        step(0, 0, 0, 0, 0, 1, 0, 0);
        drain_all(n);
        chk("R9 head at 3", head_o, 3);
        req(0, 0, 9, 0);
        chk("R9 slot0 sees slot3 store", rsp_data_o, 32'h309);
        req(3, 1, 9, 32'hB9);
        chk("R9 viol on wrap", viol_o, 1);
        chk("R9 victim slot0", viol_task_o, 0);
        step(0, 0, 0, 0, 0, 1, 0, 0);
        drain_all(n);
        chk("R7 seven stores drain len", n, 8);
        req(0, 0, 9, 0);
        chk("R2 superseded store", rsp_data_o, 32'hB9);

        // R10 space released after commit
        req(1, 0, 0, 0);
        chk("R10 not full", s_full, 0);
        chk("R10 accepted", rsp_data_o, 32'h1000);

        // Constrained random traffic obeying the controller rules
        for (int c = 0; c < 3000; c++) begin
            int r;
            r = $urandom % 100;
            if (m_drain || r >= 80) idle();
            else if (r < 70) step(1, TW'($urandom), 1'($urandom), AW'($urandom % 16), $urandom, 0, 0, 0);
            else if (r < 76) step(0, 0, 0, 0, 0, 1, 0, 0);
            else step(0, 0, 0, 0, 0, 0, 1, TW'($urandom));
        end

        done = 1;
        summary();
        $finish;
    end
endmodule